// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a burst command into a stream of column addresses, one per clock, for a synchronous graphics memory model or its controller. A mode-register write stores two settings: the ordering of the burst (linear or interleaved) and a three-bit code that gives the read latency. Each read or write command supplies a start column and a burst-length code. The block then walks the burst across a page of 2^COL_W columns. Linear order counts upward and wraps around the page. Interleaved order flips the low address bits according to the beat number.

Reads also produce a data-valid strobe. It follows each beat's column by the programmed latency. A page-long burst does not stop by itself; it runs until the terminate input is raised or a new command replaces it. Commands that ask for a combination the current mode does not allow are refused with a one-cycle error pulse. A command is also refused when the stored latency code is reserved.

Top module: `burst_col_seq`

## Requirements
- R1: When `mode_we` is high at a clock edge, `mode_ilv` is stored (1 = interleaved order, 0 = linear order) together with `mode_lat`. The stored values apply to commands sampled at later edges. After reset the order is linear and the latency code is 3'b001.
- R2: Burst-length codes on `cmd_len` are: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. Codes 4, 5 and 6 are invalid.
- R3: In linear order, beat i of a burst presents column (start + i) mod 2^COL_W.
- R4: In interleaved order, a 4-beat burst presents start XOR i in the low 2 bits and an 8-beat burst presents start XOR i in the low 3 bits. All higher column bits equal those of the start column.
- R5: A full-page burst (linear order only) keeps presenting start + i mod 2^COL_W, wrapping past the last column, until it is terminated or replaced.
- R6: A command is rejected when any of these holds: its length code is invalid; interleaved order is stored and the length is 1, 2 or full page; the stored latency code is 000 or has its top bit set. A rejected command raises `cmd_err` for exactly the next cycle, starts no burst and leaves a running burst unchanged.
- R7: Latency codes 001, 010 and 011 give latencies of 1, 2 and 3 clocks. For a read, `rd_valid` is high exactly L cycles after each cycle in which that burst presents a column. Writes never raise `rd_valid`.
- R8: The column of beat 0 appears with `col_valid` high in the cycle after the edge that accepts the command. One beat follows per clock, and `col_valid` falls in the cycle after the last beat.
- R9: An accepted command during a running burst abandons that burst. The new start column appears in the following cycle as beat 0.
- R10: `terminate` sampled high stops the burst, so `col_valid` is low in the next cycle. Read strobes already in the latency pipeline still appear on `rd_valid`. An accepted command at the same edge takes precedence over `terminate`.
- R11: During and just after reset, `col_valid`, `rd_valid` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we | input | 1 | Mode-register write strobe |
| mode_ilv | input | 1 | Burst order to store: 1 interleaved, 0 linear |
| mode_lat | input | LAT_W | Latency code to store |
| cmd_valid | input | 1 | Read or write command present |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_col | input | COL_W | Start column |
| cmd_len | input | 3 | Burst-length code |
| terminate | input | 1 | Stop the running burst |
| col_addr | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| rd_valid | output | 1 | Read data expected this cycle |
| cmd_err | output | 1 | Previous-cycle command was rejected |

## Verification
The bench builds the block with its defaults: an 8-bit column (a 256-column page), a 3-bit latency field and a maximum latency of 3. With these values the page wrap from column 255 back to 0 can be reached with short bursts, and a full-page burst crosses it within a few beats. Every legal latency, including the longest drain of three cycles after a terminate, can be exercised, and the reserved codes 000 and 1xx can be driven directly.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef struct packed {
    logic       legal;    // length code names a real length
    logic       ilv_ok;   // length usable with interleaved order
    logic       page;     // full-page burst
    logic [3:0] last;     // beats minus one (unused for page)
  } len_info_t;

  function automatic len_info_t decode_len(input logic [2:0] code);
    len_info_t r;
    r = '0;
    unique case (code)
      3'd0: begin r.legal = 1'b1; r.last = 4'd0; end
      3'd1: begin r.legal = 1'b1; r.last = 4'd1; end
      3'd2: begin r.legal = 1'b1; r.ilv_ok = 1'b1; r.last = 4'd3; end
      3'd3: begin r.legal = 1'b1; r.ilv_ok = 1'b1; r.last = 4'd7; end
      3'd7: begin r.legal = 1'b1; r.page = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bsq_mode_reg.sv
module bsq_mode_reg #(
  parameter int LAT_W   = 3,
  parameter int MAX_LAT = 3,
  localparam int LV_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             ilv_in,
  input  logic [LAT_W-1:0] lat_in,
  output logic             ilv,
  output logic [LV_W-1:0]  lat,
  output logic             lat_ok
);
  logic             ilv_q, ilv_d;
  logic [LAT_W-1:0] code_q, code_d;

  always_comb begin
    ilv_d  = ilv_q;
    code_d = code_q;
    if (we) begin
      ilv_d  = ilv_in;
      code_d = lat_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilv_q  <= 1'b0;
      code_q <= LAT_W'(1);
    end else begin
      ilv_q  <= ilv_d;
      code_q <= code_d;
    end
  end

  // codes 1..MAX_LAT are latencies, everything else is reserved
  assign lat_ok = (code_q != '0) && (int'(code_q) <= MAX_LAT);
  assign lat    = lat_ok ? LV_W'(code_q) : LV_W'(1);
  assign ilv    = ilv_q;

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ilv == $past(ilv_in))); // R1
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_read,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_ilv,
  input  logic             start_page,
  input  logic [COL_W-1:0] start_last,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             rd_strobe
);
  logic             active_q, active_d;
  logic             read_q, read_d;
  logic             ilv_q, ilv_d;
  logic             page_q, page_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] last_q, last_d;
  logic             load_en;

  assign load_en = start;

  always_comb begin
    active_d = active_q;
    read_d   = read_q;
    ilv_d    = ilv_q;
    page_d   = page_q;
    base_d   = base_q;
    beat_d   = beat_q;
    last_d   = last_q;
    if (load_en) begin
      active_d = 1'b1;
      read_d   = start_read;
      ilv_d    = start_ilv;
      page_d   = start_page;
      base_d   = start_col;
      beat_d   = '0;
      last_d   = start_last;
    end else if (active_q) begin
      if (terminate) begin
        active_d = 1'b0;
      end else if (!page_q && beat_q == last_q) begin
        active_d = 1'b0;
      end else begin
        beat_d = beat_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  // burst descriptor: no reset needed, qualified by active_q
  always_ff @(posedge clk) begin
    read_q <= read_d;
    ilv_q  <= ilv_d;
    page_q <= page_d;
    base_q <= base_d;
    beat_q <= beat_d;
    last_q <= last_d;
  end

  // interleaved bursts use last_q (3 or 7) as the flip mask
  always_comb begin
    if (ilv_q) col = (base_q & ~last_q) | ((base_q ^ beat_q) & last_q);
    else       col = base_q + beat_q;
  end

  assign col_valid = active_q;
  assign rd_strobe = active_q & read_q;

  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (terminate && !start) |=> !col_valid); // R10
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col))); // R9
  AST_ILV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && ilv_q) |-> ((col | last_q) == (base_q | last_q))); // R4
endmodule

// File: rtl/bsq_rd_pipe.sv
module bsq_rd_pipe #(
  parameter int MAX_LAT = 3,
  localparam int LV_W   = $clog2(MAX_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [LV_W-1:0] lat,
  output logic            rd_valid
);
  logic [MAX_LAT-1:0] hist_q, hist_d;

  always_comb begin
    hist_d[0] = strobe;
    for (int k = 1; k < MAX_LAT; k++) hist_d[k] = hist_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    rd_valid = 1'b0;
    for (int k = 0; k < MAX_LAT; k++)
      if (int'(lat) == k + 1) rd_valid = hist_q[k];
  end

  AST_RDV_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && lat == LV_W'(1)) |=> rd_valid); // R7
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W   = 8,
  parameter int LAT_W   = 3,
  parameter int MAX_LAT = 3,
  localparam int LV_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic             mode_ilv,
  input  logic [LAT_W-1:0] mode_lat,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       cmd_len,
  input  logic             terminate,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             rd_valid,
  output logic             cmd_err
);
  import burst_seq_pkg::*;

  logic            rst_n_s;
  logic            ilv;
  logic [LV_W-1:0] lat_cur;
  logic            lat_ok;
  len_info_t       li;
  logic            accept;
  logic            err_q, err_d;
  logic [LV_W-1:0] lat_q, lat_d;
  logic            rd_strobe;

  bsq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  bsq_mode_reg #(.LAT_W(LAT_W), .MAX_LAT(MAX_LAT)) u_mode (
    .clk(clk), .rst_n(rst_n_s), .we(mode_we), .ilv_in(mode_ilv),
    .lat_in(mode_lat), .ilv(ilv), .lat(lat_cur), .lat_ok(lat_ok)
  );

  always_comb begin
    li     = decode_len(cmd_len);
    accept = cmd_valid && lat_ok && li.legal && (!ilv || li.ilv_ok);
    err_d  = cmd_valid && !accept;
    lat_d  = accept ? lat_cur : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_q <= 1'b0;
      lat_q <= LV_W'(1);
    end else begin
      err_q <= err_d;
      lat_q <= lat_d;
    end
  end

  bsq_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_n_s), .start(accept), .start_read(cmd_read),
    .start_col(cmd_col), .start_ilv(ilv), .start_page(li.page),
    .start_last(COL_W'(li.last)), .terminate(terminate),
    .col(col_addr), .col_valid(col_valid), .rd_strobe(rd_strobe)
  );

  bsq_rd_pipe #(.MAX_LAT(MAX_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n_s), .strobe(rd_strobe), .lat(lat_q),
    .rd_valid(rd_valid)
  );

  assign cmd_err = err_q;

  AST_REJECT_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_valid && !accept && !col_valid) |=> !col_valid); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_err && !cmd_valid) |=> !cmd_err); // R6
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0, mode_ilv = 1'b0;
  logic [2:0] mode_lat = 3'd1;
  logic       cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [7:0] cmd_col = '0;
  logic [2:0] cmd_len = '0;
  logic       terminate = 1'b0;
  logic [7:0] col_addr;
  logic       col_valid, rd_valid, cmd_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_ilv(mode_ilv),
    .mode_lat(mode_lat), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_col(cmd_col), .cmd_len(cmd_len), .terminate(terminate),
    .col_addr(col_addr), .col_valid(col_valid), .rd_valid(rd_valid),
    .cmd_err(cmd_err)
  );

  typedef struct packed {
    logic       ilv;
    logic [2:0] lat;
    logic       rd;
    logic [7:0] col;
    logic [2:0] len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 3'd1, 1'b1, 8'h10, 3'd3},
    '{1'b0, 3'd2, 1'b1, 8'hFE, 3'd2},
    '{1'b0, 3'd3, 1'b0, 8'h37, 3'd1},
    '{1'b0, 3'd3, 1'b1, 8'h80, 3'd0},
    '{1'b1, 3'd2, 1'b1, 8'h5D, 3'd2},
    '{1'b1, 3'd1, 1'b0, 8'hA3, 3'd3},
    '{1'b1, 3'd3, 1'b1, 8'hFF, 3'd3},
    '{1'b0, 3'd1, 1'b0, 8'h00, 3'd3}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_col(input bit ilv, input int base, input int n, input int i);
    int m;
    if (ilv) begin
      m = n - 1;
      return (base & ~m & 255) | ((base ^ i) & m);
    end
    return (base + i) & 255;
  endfunction

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr_mode(input bit ilv, input logic [2:0] lat);
    mode_we = 1'b1; mode_ilv = ilv; mode_lat = lat;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic issue(input bit rd, input logic [7:0] col, input logic [2:0] len);
    cmd_valid = 1'b1; cmd_read = rd; cmd_col = col; cmd_len = len;
  endtask

  task automatic reject_case(input string req, input bit ilv, input logic [2:0] lat,
                             input logic [2:0] len);
    wr_mode(ilv, lat);
    issue(1'b1, 8'h20, len);
    @(negedge clk); cmd_valid = 1'b0;
    chk({req, " err raised"}, cmd_err, 1);
    chk({req, " no burst"}, col_valid, 0);
    @(negedge clk);
    chk({req, " err one cycle"}, cmd_err, 0);
    chk({req, " still idle"}, col_valid, 0);
    for (int t = 0; t < 4; t++) begin
      chk({req, " no rd_valid"}, rd_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 col_valid in reset", col_valid, 0);
    chk("R11 rd_valid in reset", rd_valid, 0);
    chk("R11 cmd_err in reset", cmd_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 col_valid after reset", col_valid, 0);
    chk("R11 cmd_err after reset", cmd_err, 0);

    // R1: reset defaults are linear order, latency 1
    issue(1'b1, 8'h40, 3'd2);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); cmd_valid = 1'b0;
      chk("R1 default linear col_valid", col_valid, int'(t < 4));
      if (t < 4) chk("R1 default linear col", col_addr, 8'h40 + t);
      chk("R1 default latency 1", rd_valid, int'(t >= 1 && t < 5));
    end

    // table walk: R3 R4 R7 R8
    foreach (VECS[v]) begin
      automatic vec_t x = VECS[v];
      automatic int n = 1 << x.len;
      automatic int L = x.lat;
      wr_mode(x.ilv, x.lat);
      issue(x.rd, x.col, x.len);
      for (int t = 0; t < n + L + 2; t++) begin
        @(negedge clk); cmd_valid = 1'b0;
        chk("R8 col_valid window", col_valid, int'(t < n));
        if (t < n)
          chk(x.ilv ? "R4 interleaved col" : "R3 linear col", col_addr,
              exp_col(x.ilv, x.col, n, t));
        chk("R7 rd_valid latency", rd_valid, int'(x.rd && t >= L && t < n + L));
      end
    end

    // R6 / R2: rejected commands
    reject_case("R6 ilv len1", 1'b1, 3'd1, 3'd0);
    reject_case("R6 ilv len2", 1'b1, 3'd1, 3'd1);
    reject_case("R6 ilv page", 1'b1, 3'd2, 3'd7);
    reject_case("R2 invalid len 5", 1'b0, 3'd1, 3'd5);
    reject_case("R7 reserved lat 000", 1'b0, 3'd0, 3'd2);
    reject_case("R7 reserved lat 100", 1'b0, 3'd4, 3'd2);

    // R6: reject during running burst leaves it unchanged
    wr_mode(1'b0, 3'd1);
    issue(1'b0, 8'h00, 3'd3);
    for (int t = 0; t < 9; t++) begin
      @(negedge clk); cmd_valid = 1'b0;
      if (t == 2) chk("R6 err during burst", cmd_err, 1);
      chk("R6 burst continues valid", col_valid, int'(t < 8));
      if (t < 8) chk("R6 burst continues col", col_addr, t);
      if (t == 1) issue(1'b0, 8'h77, 3'd6);
    end

    // R5 R10: full page with wrap, terminate, latency drain
    wr_mode(1'b0, 3'd2);
    issue(1'b1, 8'd250, 3'd7);
    for (int t = 0; t < 13; t++) begin
      @(negedge clk); cmd_valid = 1'b0; terminate = 1'b0;
      chk("R10 col_valid until terminate", col_valid, int'(t < 10));
      if (t < 10) chk("R5 page wrap col", col_addr, (250 + t) & 255);
      chk("R10 rd_valid drains", rd_valid, int'(t >= 2 && t < 12));
      if (t == 9) terminate = 1'b1;
    end

    // R9: abort by new command
    wr_mode(1'b0, 3'd1);
    issue(1'b0, 8'd10, 3'd3);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk); cmd_valid = 1'b0;
      chk("R9 restart valid", col_valid, int'(t < 7));
      if (t < 3) chk("R9 old burst col", col_addr, 10 + t);
      else if (t < 7) chk("R9 new burst col", col_addr, 100 + t - 3);
      if (t == 2) issue(1'b0, 8'd100, 3'd2);
    end

    // R10: command beats terminate at same edge
    issue(1'b0, 8'd200, 3'd3);
    for (int t = 0; t < 5; t++) begin
      @(negedge clk); cmd_valid = 1'b0; terminate = 1'b0;
      if (t == 2) begin
        chk("R10 cmd wins over terminate", col_valid, 1);
        chk("R10 cmd wins col", col_addr, 40);
      end
      if (t == 4) chk("R10 two-beat burst ends", col_valid, 0);
      if (t == 1) begin
        issue(1'b0, 8'd40, 3'd1);
        terminate = 1'b1;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule